// File: doc/BRIEF.md
# First-Level Descriptor Address Generator

This block forms the physical address of the first-level page table descriptor for a 32-bit virtual address. It keeps two table base registers, a split-control value N and a domain access word, all on one small write/read port. The value N divides the virtual address space: any address whose top N bits are not all zero is translated through the second base, and every other address goes through the first base. The first base loses low alignment bits as N grows, which allows a smaller table for the lower region. The second base is always aligned to 16 KB.

A lookup is started by pulsing the address valid strobe with the virtual address. One cycle later the block presents the descriptor address, a valid flag and a flag that names the base it used. When the memory system returns the 32-bit descriptor, the block decodes its type field and looks up the 2-bit permission of the descriptor's domain in the domain access word. This decode is purely combinational.

Top module: `l1_desc_addr_gen`

## Requirements
- R1: A write to register index 2 (control) stores only write-data bits [2:0] as N. A read of index 2 returns N in bits [2:0] with bits [31:3] zero.
- R2: Indexes 0 (base 0), 1 (base 1) and 3 (domain access word) store and read back all 32 written bits. After reset, all four indexes read zero.
- R3: When N is 0, every lookup uses base 0 (base-select flag 0), whatever the virtual address.
- R4: When N is 1 to 7, a lookup uses base 1 (flag 1) exactly when at least one of virtual address bits [31:32-N] is set. Otherwise it uses base 0.
- R5: A lookup through base 1 uses base 1 ANDed with 0xFFFFC000.
- R6: A lookup through base 0 uses base 0 ANDed with the inverse of (0x3FFF shifted right by N).
- R7: The descriptor address is the masked base ORed with virtual address bits [31:20] placed at address bits [13:2].
- R8: The descriptor address, its valid flag and the base flag appear exactly one cycle after the address valid strobe, and the valid flag is low in any cycle that does not follow a strobe. A lookup issued in the cycle after a control write already uses the new N.
- R9: The descriptor type output equals descriptor bits [1:0].
- R10: The permission output equals domain access word bits [2d+1:2d], where d is descriptor bits [8:5].
- R11: After reset, the valid flag is low and lookups behave as for N = 0, with base 0 masked by 0xFFFFC000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_idx | input | 2 | Register index: 0 base 0, 1 base 1, 2 control, 3 domain access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the indexed register (combinational) |
| va_valid | input | 1 | Lookup strobe |
| va | input | 32 | Virtual address to translate |
| desc_addr_valid | output | 1 | Descriptor address is valid |
| desc_addr | output | 32 | First-level descriptor physical address |
| desc_base_sel | output | 1 | 1 when base 1 was used, 0 when base 0 was used |
| desc_data | input | 32 | Returned first-level descriptor |
| desc_type | output | 2 | Descriptor type field |
| desc_perm | output | 2 | Access permission of the descriptor's domain |

## Verification
The assertions check on every cycle the timing of the one-cycle lookup pipeline, the word alignment of the descriptor address, the placement of the index bits in base-1 results, the rule that N = 0 never selects base 1, and the zero upper bits of a control read. Only the bench scenarios can show that the alignment of base 0 changes with N, that the selection boundary lies at the right address bit for each N, that a write takes effect on the very next lookup, and that the domain permission is taken from the right bit pair. The bench covers these with an independent model and a queue of expected results.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
  typedef enum logic [1:0] {
    REG_BASE0  = 2'd0,
    REG_BASE1  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_DOMAIN = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/ttw_regs.sv
module ttw_regs
  import ttw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NW    = 3,
  parameter int ALIGN = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    idx,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata,
  output logic [AW-1:0] base0,
  output logic [AW-1:0] base1,
  output logic [AW-1:0] dacr,
  output logic [NW-1:0] n,
  output logic [AW-1:0] sel_mask,
  output logic [AW-1:0] b0_mask
);
  localparam logic [AW-1:0] LOW_ONES = AW'((64'd1 << ALIGN) - 1);

  logic [AW-1:0] base0_q, base0_d, base1_q, base1_d, dacr_q, dacr_d;
  logic [AW-1:0] sel_q, sel_d, b0m_q, b0m_d;
  logic [NW-1:0] n_q, n_d;
  logic          ctrl_en;

  assign ctrl_en = we && (idx == REG_CTRL);

  // next-state
  always_comb begin
    base0_d = base0_q;
    base1_d = base1_q;
    dacr_d  = dacr_q;
    if (we) begin
      case (idx)
        REG_BASE0:  base0_d = wdata;
        REG_BASE1:  base1_d = wdata;
        REG_DOMAIN: dacr_d  = wdata;
        default:    ;
      endcase
    end
    n_d   = wdata[NW-1:0];
    sel_d = ~({AW{1'b1}} >> n_d);
    b0m_d = ~(LOW_ONES >> n_d);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base0_q <= '0;
      base1_q <= '0;
      dacr_q  <= '0;
      n_q     <= '0;
      sel_q   <= '0;
      b0m_q   <= ~LOW_ONES;
    end else begin
      base0_q <= base0_d;
      base1_q <= base1_d;
      dacr_q  <= dacr_d;
      if (ctrl_en) begin
        n_q   <= n_d;
        sel_q <= sel_d;
        b0m_q <= b0m_d;
      end
    end
  end

  always_comb begin
    case (idx)
      REG_BASE0:  rdata = base0_q;
      REG_BASE1:  rdata = base1_q;
      REG_CTRL:   rdata = AW'(n_q);
      default:    rdata = dacr_q;
    endcase
  end

  assign base0    = base0_q;
  assign base1    = base1_q;
  assign dacr     = dacr_q;
  assign n        = n_q;
  assign sel_mask = sel_q;
  assign b0_mask  = b0m_q;

  // R1
  ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == REG_CTRL) |-> (rdata[AW-1:NW] == '0));

  // R1
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx == REG_CTRL) |=> (n == $past(wdata[NW-1:0])));
endmodule

// File: rtl/ttw_addr.sv
module ttw_addr #(
  parameter int AW    = 32,
  parameter int NW    = 3,
  parameter int ALIGN = 14,
  parameter int SECT  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          va_valid,
  input  logic [AW-1:0] va,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] base1,
  input  logic [AW-1:0] sel_mask,
  input  logic [AW-1:0] b0_mask,
  input  logic [NW-1:0] n,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic          out_sel
);
  localparam int IDX_W = AW - SECT;
  localparam logic [AW-1:0] B1_MASK = ~AW'((64'd1 << ALIGN) - 1);

  logic          use1;
  logic [AW-1:0] masked_base, index_part, addr_d;
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic          sel_q;

  // next-state
  always_comb begin
    use1        = |(va & sel_mask);
    masked_base = use1 ? (base1 & B1_MASK) : (base0 & b0_mask);
    index_part  = AW'(va[AW-1:SECT]) << 2;
    addr_d      = masked_base | index_part;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      sel_q   <= 1'b0;
    end else begin
      valid_q <= va_valid;
      if (va_valid) begin
        addr_q <= addr_d;
        sel_q  <= use1;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_addr  = addr_q;
  assign out_sel   = sel_q;

  // R8
  lat_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    va_valid |=> out_valid);

  // R8
  lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !va_valid |=> !out_valid);

  // R7
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr[1:0] == 2'b00));

  // R7
  b1_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    va_valid |=> (!out_sel || out_addr[IDX_W+1:0] == {$past(va[AW-1:SECT]), 2'b00}));

  // R3
  n_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (va_valid && n == '0) |=> !out_sel);
endmodule

// File: rtl/ttw_desc.sv
module ttw_desc #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] desc,
  input  logic [AW-1:0] dacr,
  output logic [1:0]    dtype,
  output logic [1:0]    perm
);
  logic [3:0] dom;

  always_comb begin
    dtype = desc[1:0];
    dom   = desc[8:5];
    perm  = dacr[{dom, 1'b0} +: 2];
  end
endmodule

// File: rtl/l1_desc_addr_gen.sv
module l1_desc_addr_gen #(
  parameter int AW    = 32,
  parameter int NW    = 3,
  parameter int ALIGN = 14,
  parameter int SECT  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_idx,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          va_valid,
  input  logic [AW-1:0] va,
  output logic          desc_addr_valid,
  output logic [AW-1:0] desc_addr,
  output logic          desc_base_sel,
  input  logic [AW-1:0] desc_data,
  output logic [1:0]    desc_type,
  output logic [1:0]    desc_perm
);
  logic [AW-1:0] base0, base1, dacr, sel_mask, b0_mask;
  logic [NW-1:0] n;

  ttw_regs #(.AW(AW), .NW(NW), .ALIGN(ALIGN)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx), .wdata(reg_wdata),
    .rdata(reg_rdata), .base0(base0), .base1(base1), .dacr(dacr), .n(n),
    .sel_mask(sel_mask), .b0_mask(b0_mask)
  );

  ttw_addr #(.AW(AW), .NW(NW), .ALIGN(ALIGN), .SECT(SECT)) u_addr (
    .clk(clk), .rst_n(rst_n), .va_valid(va_valid), .va(va),
    .base0(base0), .base1(base1), .sel_mask(sel_mask), .b0_mask(b0_mask),
    .n(n), .out_valid(desc_addr_valid), .out_addr(desc_addr),
    .out_sel(desc_base_sel)
  );

  ttw_desc #(.AW(AW)) u_desc (
    .desc(desc_data), .dacr(dacr), .dtype(desc_type), .perm(desc_perm)
  );
endmodule

// File: tb/sim_l1_desc_addr_gen.sv
module sim_l1_desc_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        va_valid = 1'b0;
  logic [31:0] va = '0;
  logic        desc_addr_valid;
  logic [31:0] desc_addr;
  logic        desc_base_sel;
  logic [31:0] desc_data = '0;
  logic [1:0]  desc_type;
  logic [1:0]  desc_perm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_b0 = '0, m_b1 = '0, m_dacr = '0;
  logic [2:0]  m_n = '0;
  logic [32:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  l1_desc_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .va_valid(va_valid), .va(va),
    .desc_addr_valid(desc_addr_valid), .desc_addr(desc_addr),
    .desc_base_sel(desc_base_sel), .desc_data(desc_data),
    .desc_type(desc_type), .desc_perm(desc_perm)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d; va_valid = 1'b0;
    case (idx)
      2'd0: m_b0 = d;
      2'd1: m_b1 = d;
      2'd2: m_n = d[2:0];
      default: m_dacr = d;
    endcase
  endtask

  task automatic lookup(input logic [31:0] a);
    logic        s;
    logic [31:0] e;
    @(negedge clk);
    reg_we = 1'b0; va_valid = 1'b1; va = a;
    s = (a & ~(32'hFFFF_FFFF >> m_n)) != 0;
    e = s ? (m_b1 & 32'hFFFF_C000) : (m_b0 & ~(32'h3FFF >> m_n));
    e = e | ((a >> 18) & 32'h3FFC);
    expq.push_back({s, e});
  endtask

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      reg_we = 1'b0; va_valid = 1'b0;
    end
  endtask

  task automatic rd(input string req, input logic [1:0] idx, input logic [31:0] exp_v);
    @(negedge clk);
    reg_we = 1'b0; va_valid = 1'b0; reg_idx = idx;
    #1 check(req, 64'(reg_rdata), 64'(exp_v));
  endtask

  task automatic dsc(input logic [31:0] d);
    logic [3:0] dm;
    @(negedge clk);
    reg_we = 1'b0; va_valid = 1'b0; desc_data = d;
    dm = d[8:5];
    #1;
    check("R9 type", 64'(desc_type), 64'(d[1:0]));
    check("R10 perm", 64'(desc_perm), 64'((m_dacr >> (2*dm)) & 32'h3));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && desc_addr_valid) begin
      if (expq.size() == 0) begin
        check("R8 unexpected valid", 64'(desc_addr), 64'hDEAD);
      end else begin
        logic [32:0] it;
        it = expq.pop_front();
        check("R5/R6/R7 addr", 64'(desc_addr), 64'(it[31:0]));
        check("R3/R4 sel", 64'(desc_base_sel), 64'(it[32]));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state, R2 reset reads
    #1 check("R11 valid low", 64'(desc_addr_valid), 64'h0);
    rd("R2 reset base0", 2'd0, 32'h0);
    rd("R2 reset base1", 2'd1, 32'h0);
    rd("R1 reset ctrl", 2'd2, 32'h0);
    rd("R2 reset domain", 2'd3, 32'h0);
    // R11: base0 mask 0xFFFFC000 before any control write
    wr(2'd0, 32'hFFFF_FFFF);
    lookup(32'h0000_0000);
    lookup(32'hABC0_0000);
    wr(2'd1, 32'h8765_4321);
    wr(2'd3, 32'hE4B1_27D8);
    idle(2);
    rd("R2 base0 readback", 2'd0, 32'hFFFF_FFFF);
    rd("R2 base1 readback", 2'd1, 32'h8765_4321);
    rd("R2 domain readback", 2'd3, 32'hE4B1_27D8);
    // R1 control keeps low 3 bits
    wr(2'd2, 32'hFFFF_FFF9);
    rd("R1 ctrl readback", 2'd2, 32'h1);
    // R3 N=0 always base0
    wr(2'd2, 32'h0000_0008);
    rd("R1 ctrl masked to 0", 2'd2, 32'h0);
    lookup(32'hFFF0_0000);
    lookup(32'h8000_0000);
    // R4/R6 boundaries for several N; R8 lookup right after control write
    wr(2'd0, 32'h1234_5FFF);
    for (int k = 1; k < 8; k++) begin
      wr(2'd2, 32'(k));
      lookup(32'h1 << (32 - k));       // lowest selecting bit
      lookup(32'hFFFF_FFFF >> k);      // just below boundary
      lookup(32'h8000_0000);
      lookup(32'h0010_0000 * k);
    end
    // R5 base1 alignment with low bits set
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'h3);
    lookup(32'hE000_0000);
    lookup(32'h1FF0_0000);
    idle(3);
    check("R8 scoreboard drained", 64'(expq.size()), 64'h0);
    // R9/R10 descriptor decode
    for (int dm = 0; dm < 16; dm++) dsc(32'h0000_0000 | (dm << 5) | (dm & 3) | 32'hFFFF_FE00);
    wr(2'd3, 32'h1B6C_93F0);
    idle(1);
    dsc(32'h0000_01E2);
    dsc(32'h0000_0021);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule